// File: doc/BRIEF.md
# Dual-Mode UART Baud Tick Generator

This block turns the module clock into the 16x oversampling tick used by a UART receiver and transmitter. It also provides a bit tick on every sixteenth oversampling tick. A reload counter sets the tick spacing. That counter is stepped by one of two sources. The first is a small integer prescaler that divides the clock by 2 or by 3. The second is a fractional divider: a phase accumulator that adds a programmable increment on every clock and produces one step on each carry.

Software stops the generator before it changes the reload value. It writes the new value while the run bit is low and then raises the run bit again. A write that arrives while the generator runs is dropped. While the run bit is low, every internal counter is held at its start value and no ticks are produced. Each rise of the run bit therefore restarts the tick phase from a known point.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset, and on every cycle that follows a clock edge where `run_i` is 0, both `tick16_o` and `tick_bit_o` are 0.
- R2: With `frac_en_i` = 0 and `prescale_sel_i` = 0, the counter takes one step every 2 clocks. `tick16_o` is high for one cycle on every (reload+1)-th step.
- R3: With `frac_en_i` = 0 and `prescale_sel_i` = 1, the counter takes one step every 3 clocks. The tick spacing is 3 x (reload+1) clocks.
- R4: With `frac_en_i` = 1, the 9-bit accumulator adds `frac_div_i` on each clock and the counter steps on each carry. After n clocks of running, the tick count is floor(floor(n x F / 512) / (reload+1)).
- R5: A `frac_div_i` value of 0 acts as F = 512, so the counter steps on every clock.
- R6: `reload_wr_i` loads `reload_i` into the 13-bit reload register only on an edge where `run_i` is 0. A write on an edge where `run_i` is 1 is ignored, and the ignored value does not appear after a later stop and restart.
- R7: A rise of `run_i` restarts the prescaler, the accumulator, the reload counter and the bit divider. In prescaler mode, the first tick follows P x (reload+1) clocks, counted from the first edge that samples `run_i` high.
- R8: `tick_bit_o` is high in the same cycle as every 16th `tick16_o` pulse since the run started, and at no other time.
- R9: The reload range from 0 to 8191 is fully usable. At 8191 with the /3 prescale, the first tick comes 24576 clocks after the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Module clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Generator run enable |
| prescale_sel_i | input | 1 | Fixed prescale: 0 selects /2, 1 selects /3 |
| frac_en_i | input | 1 | 1 selects the fractional divider path |
| frac_div_i | input | 9 | Fractional increment F (0 means 512) |
| reload_wr_i | input | 1 | Reload register write strobe |
| reload_i | input | 13 | Reload value to write |
| tick16_o | output | 1 | 16x oversampling tick |
| tick_bit_o | output | 1 | Bit-rate tick |

## Verification
The hardest case to reach is a reload write that lands while the generator is running. It leaves no mark on the ports at that moment. The stimulus issues such a write in the middle of a run and keeps checking the spacing against the old value. It then stops and restarts the generator without a new write, to show that the dropped value never surfaces. Restart phase is exercised by stopping partway through a tick period. Accumulator carries that do not fall at regular intervals are checked cycle by cycle against the floor formula.

// File: rtl/brg_pkg.sv
package brg_pkg;
  localparam int unsigned RELOAD_W_DEF = 13;
  localparam int unsigned FRAC_W_DEF   = 9;
  localparam int unsigned BIT_OVS_DEF  = 16;

  typedef enum logic {
    PRE_DIV2 = 1'b0,
    PRE_DIV3 = 1'b1
  } pre_sel_e;
endpackage

// File: rtl/brg_prescale.sv
module brg_prescale
  import brg_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic sel3_i,
  output logic step_o
);
  logic [1:0] pc_q;
  logic [1:0] last;

  assign last   = (pre_sel_e'(sel3_i) == PRE_DIV3) ? 2'd2 : 2'd1;
  assign step_o = !clr_i && (pc_q >= last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pc_q <= '0;
    else if (clr_i)  pc_q <= '0;
    else if (step_o) pc_q <= '0;
    else             pc_q <= pc_q + 2'd1;
  end
endmodule

// File: rtl/brg_frac.sv
module brg_frac #(
  parameter int unsigned FRAC_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic [FRAC_W-1:0] div_i,
  output logic              step_o
);
  localparam logic [FRAC_W:0] FULL = {1'b1, {FRAC_W{1'b0}}};

  logic [FRAC_W-1:0] acc_q;
  logic [FRAC_W:0]   inc;
  logic [FRAC_W:0]   sum;

  // zero increment means a full turn per clock
  assign inc    = (div_i == '0) ? FULL : {1'b0, div_i};
  assign sum    = {1'b0, acc_q} + inc;
  assign step_o = !clr_i && sum[FRAC_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    acc_q <= '0;
    else if (clr_i) acc_q <= '0;
    else            acc_q <= sum[FRAC_W-1:0];
  end
endmodule

// File: rtl/brg_reload_cnt.sv
module brg_reload_cnt #(
  parameter int unsigned RELOAD_W = 13
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                run_i,
  input  logic                step_i,
  input  logic [RELOAD_W-1:0] reload_i,
  output logic                tick_o
);
  logic [RELOAD_W-1:0] cnt_q;
  logic                tick_q;
  logic                wrap;

  assign wrap   = run_i && step_i && (cnt_q == '0);
  assign tick_o = tick_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= wrap;
      if (!run_i || wrap) cnt_q <= reload_i;
      else if (step_i)    cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/brg_bit_div.sv
module brg_bit_div #(
  parameter int unsigned BIT_OVS = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic tick16_i,
  output logic bit_o
);
  localparam int unsigned OVS_W = $clog2(BIT_OVS);
  localparam logic [OVS_W-1:0] LAST = OVS_W'(BIT_OVS - 1);

  logic [OVS_W-1:0] bcnt_q;

  assign bit_o = tick16_i && (bcnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       bcnt_q <= '0;
    else if (!run_i)   bcnt_q <= '0;
    else if (tick16_i) bcnt_q <= bcnt_q + 1'b1;
  end
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import brg_pkg::*;
#(
  parameter int unsigned RELOAD_W = RELOAD_W_DEF,
  parameter int unsigned FRAC_W   = FRAC_W_DEF,
  parameter int unsigned BIT_OVS  = BIT_OVS_DEF
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                run_i,
  input  logic                prescale_sel_i,
  input  logic                frac_en_i,
  input  logic [FRAC_W-1:0]   frac_div_i,
  input  logic                reload_wr_i,
  input  logic [RELOAD_W-1:0] reload_i,
  output logic                tick16_o,
  output logic                tick_bit_o
);
  logic [RELOAD_W-1:0] reload_q;
  logic                pre_step;
  logic                frac_step;
  logic                step;
  logic                tick16;

  // reload only accepted while stopped
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    reload_q <= '0;
    else if (reload_wr_i && !run_i) reload_q <= reload_i;
  end

  brg_prescale u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (!run_i || frac_en_i),
    .sel3_i (prescale_sel_i),
    .step_o (pre_step)
  );

  brg_frac #(.FRAC_W(FRAC_W)) u_frac (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (!run_i || !frac_en_i),
    .div_i  (frac_div_i),
    .step_o (frac_step)
  );

  assign step = frac_en_i ? frac_step : pre_step;

  brg_reload_cnt #(.RELOAD_W(RELOAD_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run_i),
    .step_i   (step),
    .reload_i (reload_q),
    .tick_o   (tick16)
  );

  brg_bit_div #(.BIT_OVS(BIT_OVS)) u_bit (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run_i),
    .tick16_i (tick16),
    .bit_o    (tick_bit_o)
  );

  assign tick16_o = tick16;
endmodule

// File: rtl/brg_checker.sv
module brg_checker #(
  parameter int unsigned RELOAD_W = 13
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                run_i,
  input logic                frac_en_i,
  input logic [RELOAD_W-1:0] reload_q,
  input logic                tick16_o,
  input logic                tick_bit_o
);
  p_quiet_when_stopped_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (!tick16_o && !tick_bit_o));

  p_fixed_no_back_to_back_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick16_o && !frac_en_i) |=> !tick16_o);

  p_reload_lock_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |=> $stable(reload_q));

  p_no_early_tick_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(run_i) && !frac_en_i) |=> !tick16_o);

  p_bit_within_tick_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_bit_o |-> tick16_o);
endmodule

bind baud_tick_gen brg_checker #(.RELOAD_W(RELOAD_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .run_i      (run_i),
  .frac_en_i  (frac_en_i),
  .reload_q   (reload_q),
  .tick16_o   (tick16_o),
  .tick_bit_o (tick_bit_o)
);

// File: tb/sim_baud_tick_gen.sv
`timescale 1ns/1ps
module sim_baud_tick_gen;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        run_i = 1'b0;
  logic        prescale_sel_i = 1'b0;
  logic        frac_en_i = 1'b0;
  logic [8:0]  frac_div_i = '0;
  logic        reload_wr_i = 1'b0;
  logic [12:0] reload_i = '0;
  logic        tick16_o;
  logic        tick_bit_o;

  typedef struct packed {
    logic       t16;
    logic       tb;
    logic [7:0] req;
  } exp_t;

  exp_t q[$];
  int   vectors = 0;
  int   fails = 0;
  bit   done = 1'b0;

  always #5 clk_i = ~clk_i;

  baud_tick_gen u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run_i),
    .prescale_sel_i(prescale_sel_i), .frac_en_i(frac_en_i),
    .frac_div_i(frac_div_i), .reload_wr_i(reload_wr_i),
    .reload_i(reload_i), .tick16_o(tick16_o), .tick_bit_o(tick_bit_o)
  );

  // monitor
  always @(negedge clk_i) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      vectors++;
      if (tick16_o !== e.t16 || tick_bit_o !== e.tb) begin
        fails++;
        $display("FAIL R%0d t=%0t tick16/bit actual %b%b expected %b%b",
                 e.req, $time, tick16_o, tick_bit_o, e.t16, e.tb);
      end
    end
  end

  function automatic longint steps(bit frac, bit sel3, int fdv, longint k);
    longint f;
    f = (fdv == 0) ? 512 : fdv;
    if (frac) return (k * f) / 512;
    return k / (sel3 ? 3 : 2);
  endfunction

  task automatic load(int v);
    @(negedge clk_i);
    reload_wr_i = 1'b1; reload_i = 13'(v);
    @(negedge clk_i);
    reload_wr_i = 1'b0;
  endtask

  task automatic stop();
    @(negedge clk_i);
    run_i = 1'b0;
  endtask

  // drive a run and queue the expected outputs after every edge
  task automatic run_case(bit frac, bit sel3, int fdv, int rl, int n, int req, int wr_at);
    longint tk, tp;
    @(negedge clk_i);
    frac_en_i = frac; prescale_sel_i = sel3; frac_div_i = 9'(fdv); run_i = 1'b1;
    tp = 0;
    for (int k = 1; k <= n; k++) begin
      exp_t e;
      @(posedge clk_i);
      tk = steps(frac, sel3, fdv, k) / (rl + 1);
      e.t16 = (tk > tp);
      e.tb  = e.t16 && (tk % 16 == 0);
      e.req = 8'(req);
      q.push_back(e);
      tp = tk;
      if (wr_at > 0 && k == wr_at) begin
        @(negedge clk_i); reload_wr_i = 1'b1; reload_i = 13'd1;
      end else if (wr_at > 0 && k == wr_at + 1) begin
        @(negedge clk_i); reload_wr_i = 1'b0;
      end
    end
    @(negedge clk_i);
  endtask

  task automatic idle(int n, int req);
    for (int k = 0; k < n; k++) begin
      exp_t e;
      @(posedge clk_i);
      e.t16 = 1'b0; e.tb = 1'b0; e.req = 8'(req);
      q.push_back(e);
    end
    @(negedge clk_i);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    #23 rst_ni = 1'b1;
    @(negedge clk_i);
    vectors++;
    if (tick16_o !== 1'b0 || tick_bit_o !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset outputs actual %b%b expected 00", tick16_o, tick_bit_o);
    end
    idle(20, 1);                         // R1 stopped: quiet
    load(0);
    run_case(0, 0, 0, 0, 100, 2, 0);     // R2 and R8 bit tick every 32 clocks
    stop();
    load(4);
    run_case(0, 0, 0, 4, 60, 2, 0);      // R2
    stop();
    idle(10, 1);                         // R1
    load(2);
    run_case(0, 1, 0, 2, 60, 3, 0);      // R3
    stop();
    load(3);
    run_case(1, 0, 300, 3, 200, 4, 0);   // R4 irregular carries
    stop();
    load(1);
    run_case(1, 0, 128, 1, 50, 4, 0);    // R4
    stop();
    load(0);
    run_case(1, 0, 0, 0, 40, 5, 0);      // R5 and R8 at full rate
    stop();
    load(3);
    run_case(1, 0, 0, 3, 40, 5, 0);      // R5
    stop();
    load(5);
    run_case(0, 0, 0, 5, 60, 6, 17);     // R6 write while running dropped
    stop();
    run_case(0, 0, 0, 5, 40, 6, 0);      // R6 old value still in force
    stop();
    load(1);
    run_case(0, 0, 0, 1, 40, 6, 0);      // R6 write while stopped taken
    stop();
    load(3);
    run_case(0, 1, 0, 3, 20, 7, 0);      // R7 stop mid period
    stop();
    run_case(0, 1, 0, 3, 40, 7, 0);      // R7 phase restarts
    stop();
    load(8191);
    run_case(0, 1, 0, 8191, 24580, 9, 0); // R9 top of range
    stop();
    idle(4, 1);
    while (q.size() > 0) @(negedge clk_i);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule